// File: doc/BRIEF.md
# Six-Channel PWM Generator with Pairwise 16-bit Joining

This block produces six pulse-width modulated outputs from one system clock. Every channel owns an 8-bit up-counter, a period value and a duty value. All counters step on a common prescaler tick, which is a one-cycle pulse issued every `PRESC_DIV` system clocks. A channel drives its line high while its counter is below its duty value. The counter wraps to zero once the next count would reach the period.

Neighbouring channels can be joined in pairs: 0 with 1, 2 with 3, and 4 with 5. A joined pair acts as a single 16-bit channel. The even channel supplies the upper byte of the counter, period and duty, and the odd channel supplies the lower byte. The joined channel is started and stopped by the odd channel's enable bit alone, and it drives its waveform on the odd line. The even line stays low.

Software sets up the block through a small synchronous register port. A newly enabled channel starts its waveform only on a prescaler tick. When every enable bit is clear, the prescaler stops counting to save power.

Top module: `pwm_six_chan`

## Requirements
- R1: The channel-enable register sits at address 0. It holds six bits, bit i for channel i, and resets to zero. Writing it takes effect at the write edge. Bits 7 and 6 always read as 0, and writes to them are ignored.
- R2: Address 1 holds the join controls. Bit 0 joins pair 0/1, bit 1 joins pair 2/3, and bit 2 joins pair 4/5; bits 7..3 read as 0. Addresses 2+i hold the period of channel i and addresses 8+i hold its duty, for i = 0..5. Every register reads back its stored value, and addresses 14 and 15 read as 0. All values reset to zero.
- R3: While at least one enable bit is set, `prescale_tick` is high for exactly one cycle in every `PRESC_DIV` cycles. A write that makes the enable register nonzero while it was all zero restarts the prescaler from zero. The first tick is then high in the `PRESC_DIV`-th cycle after the write edge.
- R4: While all six enable bits are zero, the prescaler count holds its value and `prescale_tick` stays low.
- R5: A channel that has just been enabled keeps its output low until the first clock edge at which `prescale_tick` is high. Its waveform starts at that edge, with its counter at 0.
- R6: An unjoined, active channel advances its counter by one on each tick. It returns the counter to 0 when count+1 is greater than or equal to its period. Its output is high exactly while count < duty.
- R7: Clearing a channel's enable bit drives its output low from the write edge onward. Its counter returns to 0, so a later enable starts a fresh period.
- R8: In a joined pair, {even, odd} form the 16-bit counter, period and duty, and the same counting rule as R6 applies. The odd line carries the waveform, and only the odd enable bit starts or stops it.
- R9: While a pair is joined, its even output stays low, whatever the state of the even enable bit.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Write strobe, sampled on the rising clock edge |
| reg_addr | input | 4 | Register address for reads and writes |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| pwm_out | output | 6 | PWM lines, bit i for channel i |
| prescale_tick | output | 1 | Shared prescaler tick |

## Verification
Register reads are combinational, so a write's effect can be read back half a cycle after its write edge. A disable shows up on `pwm_out` in the same half cycle. After a restarting enable write, the tick is due in the `PRESC_DIV`-th cycle, and the waveform appears one cycle later, once the tick edge has set the channel active. The bench drives inputs on the falling edge and advances its reference model at the rising edge. It compares outputs on the following falling edge, so each comparison holds the exact cycle in which a result is due. The directed checks count falling edges from the write edge and expect the tick at `PRESC_DIV` and the first high output at `PRESC_DIV`+1.

// File: rtl/pwm_six_pkg.sv
package pwm_six_pkg;
  localparam int CNT_W  = 8;
  localparam int PAIR_W = 2 * CNT_W;

  // Next counter value: wrap to zero once count+1 reaches the period.
  function automatic logic [PAIR_W-1:0] wrap_step(input logic [PAIR_W-1:0] c,
                                                  input logic [PAIR_W-1:0] p);
    logic [PAIR_W:0] s;
    s = {1'b0, c} + {{PAIR_W{1'b0}}, 1'b1};
    return (s >= {1'b0, p}) ? '0 : s[PAIR_W-1:0];
  endfunction

  // Output level: high while the counter is below the duty value.
  function automatic logic duty_hit(input logic [PAIR_W-1:0] c,
                                    input logic [PAIR_W-1:0] d);
    return c < d;
  endfunction
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int DIV = 4,
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         restart,
  output logic         tick,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  always_ff @(posedge clk) begin
    if (!rst_n)       count <= '0;
    else if (restart) count <= '0;
    else if (run)     count <= (count == LAST) ? '0 : count + W'(1);
  end

  assign tick = run & (count == LAST);
endmodule

// File: rtl/pwm_pair.sv
module pwm_pair
  import pwm_six_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             join_en,
  input  logic             en_hi,
  input  logic             en_lo,
  input  logic [CNT_W-1:0] per_hi,
  input  logic [CNT_W-1:0] per_lo,
  input  logic [CNT_W-1:0] duty_hi,
  input  logic [CNT_W-1:0] duty_lo,
  output logic             out_hi,
  output logic             out_lo,
  output logic             act_hi,
  output logic             act_lo
);
  logic              raw_hi, raw_lo;
  logic [CNT_W-1:0]  cnt_hi, cnt_lo, nxt_hi, nxt_lo;
  logic [CNT_W-1:0]  unused_hi, unused_lo;
  logic [PAIR_W-1:0] cnt_j, per_j, duty_j, nxt_j;

  // The even enable is void while joined; the odd one governs the pair.
  assign raw_hi = en_hi & ~join_en;
  assign raw_lo = en_lo;

  assign cnt_j  = {cnt_hi, cnt_lo};
  assign per_j  = {per_hi, per_lo};
  assign duty_j = {duty_hi, duty_lo};
  assign nxt_j  = wrap_step(cnt_j, per_j);
  assign {unused_hi, nxt_hi} = wrap_step(PAIR_W'(cnt_hi), PAIR_W'(per_hi));
  assign {unused_lo, nxt_lo} = wrap_step(PAIR_W'(cnt_lo), PAIR_W'(per_lo));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_hi <= 1'b0;
      act_lo <= 1'b0;
      cnt_hi <= '0;
      cnt_lo <= '0;
    end else begin
      act_hi <= raw_hi & (act_hi | tick);
      act_lo <= raw_lo & (act_lo | tick);
      if (join_en) begin
        if (!act_lo)   {cnt_hi, cnt_lo} <= '0;
        else if (tick) {cnt_hi, cnt_lo} <= nxt_j;
      end else begin
        if (!act_hi)   cnt_hi <= '0;
        else if (tick) cnt_hi <= nxt_hi;
        if (!act_lo)   cnt_lo <= '0;
        else if (tick) cnt_lo <= nxt_lo;
      end
    end
  end

  assign out_hi = act_hi & raw_hi & duty_hit(PAIR_W'(cnt_hi), PAIR_W'(duty_hi));
  assign out_lo = act_lo & raw_lo &
                  (join_en ? duty_hit(cnt_j, duty_j)
                           : duty_hit(PAIR_W'(cnt_lo), PAIR_W'(duty_lo)));
endmodule

// File: rtl/pwm_six_chan.sv
module pwm_six_chan
  import pwm_six_pkg::*;
#(
  parameter int PRESC_DIV = 4,
  parameter int NPAIR     = 3,
  parameter int AW        = 4,
  parameter int DW        = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_we,
  input  logic [AW-1:0]        reg_addr,
  input  logic [DW-1:0]        reg_wdata,
  output logic [DW-1:0]        reg_rdata,
  output logic [2*NPAIR-1:0]   pwm_out,
  output logic                 prescale_tick
);
  localparam int NCH      = 2 * NPAIR;
  localparam int PW       = (PRESC_DIV > 1) ? $clog2(PRESC_DIV) : 1;
  localparam int EN_ADDR  = 0;
  localparam int JN_ADDR  = 1;
  localparam int PER_BASE = 2;
  localparam int DUT_BASE = PER_BASE + NCH;

  logic [NCH-1:0]   en_q;
  logic [NPAIR-1:0] join_q;
  logic [CNT_W-1:0] per_q  [NCH];
  logic [CNT_W-1:0] duty_q [NCH];
  logic             any_en, presc_restart;
  logic [PW-1:0]    presc_cnt;
  logic [NCH-1:0]   ch_act;
  logic             unused_wbits;

  assign unused_wbits = ^reg_wdata[DW-1:NCH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      join_q <= '0;
      for (int i = 0; i < NCH; i++) begin
        per_q[i]  <= '0;
        duty_q[i] <= '0;
      end
    end else if (reg_we) begin
      if (reg_addr == AW'(EN_ADDR)) en_q   <= reg_wdata[NCH-1:0];
      if (reg_addr == AW'(JN_ADDR)) join_q <= reg_wdata[NPAIR-1:0];
      for (int i = 0; i < NCH; i++) begin
        if (reg_addr == AW'(PER_BASE + i)) per_q[i]  <= reg_wdata[CNT_W-1:0];
        if (reg_addr == AW'(DUT_BASE + i)) duty_q[i] <= reg_wdata[CNT_W-1:0];
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == AW'(EN_ADDR)) reg_rdata = DW'(en_q);
    if (reg_addr == AW'(JN_ADDR)) reg_rdata = DW'(join_q);
    for (int i = 0; i < NCH; i++) begin
      if (reg_addr == AW'(PER_BASE + i)) reg_rdata = DW'(per_q[i]);
      if (reg_addr == AW'(DUT_BASE + i)) reg_rdata = DW'(duty_q[i]);
    end
  end

  assign any_en        = |en_q;
  assign presc_restart = reg_we && (reg_addr == AW'(EN_ADDR)) &&
                         (|reg_wdata[NCH-1:0]) && !any_en;

  pwm_prescaler #(.DIV(PRESC_DIV)) u_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (any_en),
    .restart (presc_restart),
    .tick    (prescale_tick),
    .count   (presc_cnt)
  );

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    pwm_pair u_pair (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (prescale_tick),
      .join_en (join_q[p]),
      .en_hi   (en_q[2*p]),
      .en_lo   (en_q[2*p+1]),
      .per_hi  (per_q[2*p]),
      .per_lo  (per_q[2*p+1]),
      .duty_hi (duty_q[2*p]),
      .duty_lo (duty_q[2*p+1]),
      .out_hi  (pwm_out[2*p]),
      .out_lo  (pwm_out[2*p+1]),
      .act_hi  (ch_act[2*p]),
      .act_lo  (ch_act[2*p+1])
    );
  end
endmodule

// File: rtl/pwm_six_chan_chk.sv
module pwm_six_chan_chk #(
  parameter int NPAIR = 3,
  parameter int PW    = 2,
  parameter int AW    = 4,
  parameter int DW    = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [AW-1:0]      reg_addr,
  input logic [DW-1:0]      reg_rdata,
  input logic [2*NPAIR-1:0] en_q,
  input logic [NPAIR-1:0]   join_q,
  input logic               presc_restart,
  input logic [PW-1:0]      presc_cnt,
  input logic               prescale_tick,
  input logic [2*NPAIR-1:0] ch_act,
  input logic [2*NPAIR-1:0] pwm_out
);
  localparam int NCH = 2 * NPAIR;

  p_top_bits_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == '0) |-> (reg_rdata[DW-1:NCH] == '0));

  p_tick_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    prescale_tick |=> !prescale_tick);

  p_tick_needs_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
    prescale_tick |-> (|en_q));

  p_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|en_q) && !presc_restart) |=> $stable(presc_cnt));

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    p_start_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ch_act[i]) |-> $past(prescale_tick));
    p_out_needs_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
      pwm_out[i] |-> en_q[i]);
  end

  for (genvar p = 0; p < NPAIR; p++) begin : g_pr
    p_even_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
      join_q[p] |-> !pwm_out[2*p]);
  end
endmodule

bind pwm_six_chan pwm_six_chan_chk #(.NPAIR(NPAIR), .PW(PW), .AW(AW), .DW(DW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .reg_addr      (reg_addr),
  .reg_rdata     (reg_rdata),
  .en_q          (en_q),
  .join_q        (join_q),
  .presc_restart (presc_restart),
  .presc_cnt     (presc_cnt),
  .prescale_tick (prescale_tick),
  .ch_act        (ch_act),
  .pwm_out       (pwm_out)
);

// File: tb/test_pwm_six_chan.sv
module test_pwm_six_chan;
  localparam int DIV = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [5:0] pwm_out;
  logic       prescale_tick;

  always #4 clk = ~clk;

  pwm_six_chan #(.PRESC_DIV(DIV)) i_pwm_six_chan (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_out(pwm_out),
    .prescale_tick(prescale_tick)
  );

  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 0;
  string cur_tag = "R6";

  // Reference model state
  bit [5:0] m_en;
  bit [2:0] m_join;
  int       m_per [6];
  int       m_duty [6];
  int       m_pc;
  bit [5:0] m_act;
  int       m_cnt [6];

  function automatic bit m_tick();
    return (m_en != 0) && (m_pc == DIV - 1);
  endfunction

  function automatic bit [5:0] m_raw();
    bit [5:0] r;
    for (int p = 0; p < 3; p++) begin
      r[2*p+1] = m_en[2*p+1];
      r[2*p]   = m_en[2*p] & !m_join[p];
    end
    return r;
  endfunction

  function automatic bit [5:0] m_out();
    bit [5:0] o;
    bit [5:0] r;
    r = m_raw();
    o = '0;
    for (int p = 0; p < 3; p++) begin
      if (m_join[p]) begin
        int c16 = m_cnt[2*p] * 256 + m_cnt[2*p+1];
        int d16 = m_duty[2*p] * 256 + m_duty[2*p+1];
        o[2*p+1] = m_act[2*p+1] & r[2*p+1] & (c16 < d16);
      end else begin
        for (int k = 2*p; k <= 2*p+1; k++)
          o[k] = m_act[k] & r[k] & (m_cnt[k] < m_duty[k]);
      end
    end
    return o;
  endfunction

  function automatic int wrapped(int c, int per);
    return (c + 1 >= per) ? 0 : c + 1;
  endfunction

  function automatic bit [7:0] exp_rd(int a);
    if (a == 0) return {2'b00, m_en};
    if (a == 1) return {5'b0, m_join};
    if (a >= 2 && a < 8) return 8'(m_per[a-2]);
    if (a >= 8 && a < 14) return 8'(m_duty[a-8]);
    return 8'h00;
  endfunction

  task automatic model_reset();
    m_en = '0; m_join = '0; m_pc = 0; m_act = '0;
    for (int i = 0; i < 6; i++) begin
      m_per[i] = 0; m_duty[i] = 0; m_cnt[i] = 0;
    end
  endtask

  task automatic model_step();
    bit tk;
    bit [5:0] r;
    bit [5:0] na;
    tk = m_tick();
    r  = m_raw();
    for (int i = 0; i < 6; i++) na[i] = r[i] & (m_act[i] | tk);
    for (int p = 0; p < 3; p++) begin
      if (m_join[p]) begin
        int c16 = m_cnt[2*p] * 256 + m_cnt[2*p+1];
        int p16 = m_per[2*p] * 256 + m_per[2*p+1];
        if (!m_act[2*p+1]) c16 = 0;
        else if (tk) c16 = wrapped(c16, p16);
        m_cnt[2*p] = c16 / 256;
        m_cnt[2*p+1] = c16 % 256;
      end else begin
        for (int k = 2*p; k <= 2*p+1; k++) begin
          if (!m_act[k]) m_cnt[k] = 0;
          else if (tk) m_cnt[k] = wrapped(m_cnt[k], m_per[k]);
        end
      end
    end
    if (reg_we && reg_addr == 0 && reg_wdata[5:0] != 0 && m_en == 0) m_pc = 0;
    else if (m_en != 0) m_pc = (m_pc == DIV - 1) ? 0 : m_pc + 1;
    m_act = na;
    if (reg_we) begin
      if (reg_addr == 0) m_en = reg_wdata[5:0];
      else if (reg_addr == 1) m_join = reg_wdata[2:0];
      else if (reg_addr < 8) m_per[reg_addr-2] = reg_wdata;
      else if (reg_addr < 14) m_duty[reg_addr-8] = reg_wdata;
    end
  endtask

  task automatic check(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // One clock: model advances at the edge, outputs compared at the falling edge.
  task automatic step();
    @(posedge clk);
    model_step();
    @(negedge clk);
    check(pwm_out === m_out(), cur_tag, "pwm_out", int'(pwm_out), int'(m_out()));
    check(prescale_tick === m_tick(), cur_tag, "prescale_tick",
          int'(prescale_tick), int'(m_tick()));
  endtask

  task automatic wr(int a, int d);
    reg_we = 1'b1; reg_addr = 4'(a); reg_wdata = 8'(d);
    step();
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(int a, string tag);
    reg_addr = 4'(a);
    #1;
    check(reg_rdata === exp_rd(a), tag, $sformatf("read addr %0d", a),
          int'(reg_rdata), int'(exp_rd(a)));
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int t_tick, t_out;
    void'($urandom(32'h5eed_1234));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset values
    check(pwm_out === 6'h00, "R1", "pwm_out after reset", int'(pwm_out), 0);
    check(prescale_tick === 1'b0, "R1", "tick after reset", int'(prescale_tick), 0);
    for (int a = 0; a < 16; a++) rd_chk(a, "R2");

    // R1: upper enable bits ignored
    wr(0, 8'hFF);
    rd_chk(0, "R1");
    check(reg_rdata === 8'h3F, "R1", "enable readback", int'(reg_rdata), 8'h3F);
    wr(0, 0);
    run(3);

    // R2: register map readback
    cur_tag = "R2";
    for (int a = 1; a < 16; a++) begin
      wr(a, $urandom & 8'hFF);
      rd_chk(a, "R2");
    end
    wr(1, 0);

    // R4: frozen prescaler, no ticks with all enables clear
    cur_tag = "R4";
    for (int i = 0; i < 12; i++) begin
      step();
      check(prescale_tick === 1'b0, "R4", "tick while idle", int'(prescale_tick), 0);
    end

    // R3 / R5: restart timing, channel 3 period 5 duty 2
    cur_tag = "R5";
    wr(5, 5); wr(11, 2);
    wr(0, 8'h08);
    t_tick = 0; t_out = 0;
    for (int k = 1; k <= 3 * DIV; k++) begin
      if (k > 1) step();
      if (t_tick == 0 && prescale_tick) t_tick = k;
      if (t_out == 0 && pwm_out[3]) t_out = k;
    end
    check(t_tick == DIV, "R3", "first tick cycle", t_tick, DIV);
    check(t_out == DIV + 1, "R5", "first high cycle", t_out, DIV + 1);
    cur_tag = "R6";
    run(60);

    // R7: always-high channel goes low at the disabling write edge
    cur_tag = "R7";
    wr(4, 4); wr(10, 4); wr(0, 8'h0C);
    run(3 * DIV);
    check(pwm_out[2] === 1'b1, "R7", "ch2 high before disable", int'(pwm_out[2]), 1);
    wr(0, 8'h08);
    check(pwm_out[2] === 1'b0, "R7", "ch2 low after disable", int'(pwm_out[2]), 0);
    run(2 * DIV);
    wr(0, 0);
    run(4);

    // R8 / R9: join pair 0/1 as 16-bit (period 0x0102, duty 0x0100), even enable set too
    cur_tag = "R8";
    wr(2, 1); wr(3, 2); wr(8, 1); wr(9, 0); wr(6, 3); wr(12, 8'hFF);
    wr(1, 1);
    wr(0, 8'h03);
    for (int i = 0; i < 270 * DIV; i++) begin
      step();
      check(pwm_out[0] === 1'b0, "R9", "even line while joined", int'(pwm_out[0]), 0);
    end
    wr(0, 8'h01);
    check(pwm_out[1] === 1'b0, "R8", "odd enable off stops pair", int'(pwm_out[1]), 0);
    run(20);
    wr(1, 0); wr(0, 0);
    run(4);

    // Random mix checked against the model
    cur_tag = "R6";
    for (int i = 0; i < 3000; i++) begin
      if (($urandom % 8) == 0) begin
        int a = $urandom % 16;
        int d = $urandom & 8'hFF;
        if (a >= 2 && a < 14 && ($urandom % 4) != 0) d = d & 7;
        if (a == 0 && ($urandom % 4) == 0) d = 0;
        wr(a, d);
        rd_chk(a, "R2");
      end else begin
        step();
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule